// File: doc/BRIEF.md
# Calibration Cycle Sequencer

This block runs the digital side of a converter's self-calibration. Each time the active-low calibration strobe goes from high to low, the block starts a unit calibration cycle that lasts a fixed number of clocks. It steps a phase index through that cycle and raises a flag for the four phases in which the calibration logic borrows the fine comparator. While that flag is up, the block holds the lower bits of the converted sample it passes on. The upper bits keep following the input.

Completed unit cycles are grouped into calibration processes of seven cycles each. At the end of every process the block emits a one-clock strobe. It also keeps a saturating count of processes and asserts a completion flag once the count reaches the worst-case total needed for full calibration. A falling strobe edge that lands while a unit cycle is still running is dropped, not queued. The sample path is a single register stage, so every output bit lags its input by one clock.

Top module: `cal_cycle_seq`

## Requirements
- R1: After reset, cal_busy_o, fine_busy_o, proc_done_o and cal_complete_o are 0, while phase_o, proc_count_o and sample_o are all zero.
- R2: A clock edge that samples cal_pulse_ni low, after the previous edge sampled it high, starts a unit cycle when none is running. cal_busy_o is 1 and phase_o is 0 after that edge. A strobe held low does not start another cycle, and a strobe already low when reset is released does not start one.
- R3: A unit cycle keeps cal_busy_o at 1 for exactly 7 clocks, with phase_o taking the values 0,1,...,6 in turn. cal_busy_o then returns to 0 and phase_o returns to 0.
- R4: fine_busy_o is 1 exactly while a cycle is in phases 1 to 4 inclusive, which is four clocks, and 0 at all other times.
- R5: On every clock edge, sample_o[9:5] registers sample_i[9:5]. sample_o[4:0] registers sample_i[4:0] on every edge at which fine_busy_o is 0, and keeps its value on every edge at which fine_busy_o is 1.
- R6: A falling strobe edge sampled while a cycle is running is ignored. It neither restarts nor extends the cycle, it is not queued to start a cycle later, and it does not count toward a process.
- R7: proc_done_o is 1 for exactly one clock, the clock right after the seventh unit cycle of a process ends. It fires again after every further seven cycles.
- R8: proc_count_o increments by one with each proc_done_o pulse and saturates at 80. cal_complete_o is 1 exactly when proc_count_o equals 80.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cal_pulse_ni | input | 1 | Active-low calibration strobe; a falling edge requests a unit cycle |
| sample_i | input | 10 | Converted sample from the datapath |
| cal_busy_o | output | 1 | A unit calibration cycle is running |
| fine_busy_o | output | 1 | Fine comparator is taken by calibration |
| phase_o | output | 3 | Phase index within the running unit cycle |
| proc_done_o | output | 1 | One-clock strobe at the end of every seventh unit cycle |
| proc_count_o | output | 7 | Saturating count of completed processes |
| cal_complete_o | output | 1 | Worst-case process total reached |
| sample_o | output | 10 | Registered sample with its low five bits frozen while the comparator is taken |

## Verification
Several properties are checked on every clock. Phases advance by one and a cycle ends after the last phase. A cycle starts on an edge seen while idle. The comparator flag never appears outside a cycle. The low sample field stays still across a frozen edge, and the high field always follows the input. The done strobe is never two clocks wide and only follows a cycle end, and the process count never wraps past its ceiling. Only the bench scenarios can show the things that span many cycles or depend on history. These are that a retriggering edge is dropped rather than queued, that a held-low strobe does not restart a cycle, that the done strobe lands on exactly every seventh cycle, and the exact cycle on which the completion flag rises at 80 processes.

// File: rtl/cal_seq_pkg.sv
package cal_seq_pkg;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_run_e;

endpackage

// File: rtl/calseq_edge.sv
module calseq_edge (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic strobe_ni,
    output logic fall_o
);

    typedef struct packed {
        logic level;
    } edge_state_t;

    edge_state_t s_d, s_q;

    // Reset value low: a strobe already low at reset release is not an edge.
    always_comb begin
        s_d       = s_q;
        s_d.level = strobe_ni;
        fall_o    = s_q.level & ~strobe_ni;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

endmodule

// File: rtl/calseq_timer.sv
module calseq_timer
    import cal_seq_pkg::*;
#(
    parameter int CYC_LEN    = 7,
    parameter int FINE_START = 1,
    parameter int FINE_LEN   = 4,
    localparam int PH_W      = (CYC_LEN > 1) ? $clog2(CYC_LEN) : 1
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            fall_i,
    output logic            busy_o,
    output logic            fine_o,
    output logic            end_o,
    output logic [PH_W-1:0] phase_o
);

    localparam logic [PH_W-1:0] PH_LAST  = PH_W'(CYC_LEN - 1);
    localparam logic [PH_W-1:0] PH_FINE0 = PH_W'(FINE_START);
    localparam logic [PH_W-1:0] PH_FINE1 = PH_W'(FINE_START + FINE_LEN - 1);

    typedef struct packed {
        seq_run_e        st;
        logic [PH_W-1:0] phase;
    } timer_state_t;

    timer_state_t s_d, s_q;

    always_comb begin
        s_d   = s_q;
        end_o = 1'b0;
        unique case (s_q.st)
            SEQ_IDLE: begin
                if (fall_i) begin
                    s_d.st    = SEQ_RUN;
                    s_d.phase = '0;
                end
            end
            SEQ_RUN: begin
                if (s_q.phase == PH_LAST) begin
                    end_o     = 1'b1;
                    s_d.st    = SEQ_IDLE;
                    s_d.phase = '0;
                end else begin
                    s_d.phase = s_q.phase + PH_W'(1);
                end
            end
            default: s_d = '0;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign busy_o  = (s_q.st == SEQ_RUN);
    assign phase_o = s_q.phase;
    assign fine_o  = busy_o && (s_q.phase >= PH_FINE0) && (s_q.phase <= PH_FINE1);

    a_r2_start_from_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (fall_i && !busy_o) |=> (busy_o && phase_o == '0));

    a_r3_phase_steps: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && phase_o != PH_LAST) |=> (busy_o && phase_o == $past(phase_o) + PH_W'(1)));

    a_r3_cycle_ends: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && phase_o == PH_LAST) |=> (!busy_o && phase_o == '0));

    a_r6_no_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && fall_i && phase_o != PH_LAST) |=> (phase_o != '0));

endmodule

// File: rtl/calseq_tally.sv
module calseq_tally #(
    parameter int UNITS_PER_PROC = 7,
    parameter int PROC_MAX       = 80,
    localparam int UNIT_W        = (UNITS_PER_PROC > 1) ? $clog2(UNITS_PER_PROC) : 1,
    localparam int PC_W          = $clog2(PROC_MAX + 1)
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            end_i,
    output logic            done_o,
    output logic            complete_o,
    output logic [PC_W-1:0] count_o
);

    localparam logic [UNIT_W-1:0] UNIT_LAST = UNIT_W'(UNITS_PER_PROC - 1);
    localparam logic [PC_W-1:0]   PC_TOP    = PC_W'(PROC_MAX);

    typedef struct packed {
        logic [UNIT_W-1:0] units;
        logic [PC_W-1:0]   procs;
        logic              done;
    } tally_state_t;

    tally_state_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        if (end_i) begin
            if (s_q.units == UNIT_LAST) begin
                s_d.units = '0;
                s_d.done  = 1'b1;
                if (s_q.procs != PC_TOP) s_d.procs = s_q.procs + PC_W'(1);
            end else begin
                s_d.units = s_q.units + UNIT_W'(1);
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign done_o     = s_q.done;
    assign count_o    = s_q.procs;
    assign complete_o = (s_q.procs == PC_TOP);

    a_r7_done_one_clock: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);

    a_r7_done_after_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(done_o) |-> $past(end_i));

    a_r8_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (count_o == PC_TOP) |=> (count_o == PC_TOP));

    a_r8_step_on_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($rose(done_o) && $past(count_o) != PC_TOP) |-> (count_o == $past(count_o) + PC_W'(1)));

endmodule

// File: rtl/calseq_hold.sv
module calseq_hold #(
    parameter int DATA_W = 10,
    parameter int LO_W   = 5
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              freeze_i,
    input  logic [DATA_W-1:0] sample_i,
    output logic [DATA_W-1:0] sample_o
);

    typedef struct packed {
        logic [DATA_W-LO_W-1:0] hi;
        logic [LO_W-1:0]        lo;
    } hold_state_t;

    hold_state_t s_d, s_q;

    always_comb begin
        s_d    = s_q;
        s_d.hi = sample_i[DATA_W-1:LO_W];
        if (!freeze_i) s_d.lo = sample_i[LO_W-1:0];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign sample_o = {s_q.hi, s_q.lo};

    a_r5_low_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
        freeze_i |=> $stable(sample_o[LO_W-1:0]));

    a_r5_high_tracks: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> (sample_o[DATA_W-1:LO_W] == $past(sample_i[DATA_W-1:LO_W])));

endmodule

// File: rtl/cal_cycle_seq.sv
module cal_cycle_seq
    import cal_seq_pkg::*;
#(
    parameter int DATA_W         = 10,
    parameter int LO_W           = 5,
    parameter int CYC_LEN        = 7,
    parameter int FINE_START     = 1,
    parameter int FINE_LEN       = 4,
    parameter int UNITS_PER_PROC = 7,
    parameter int PROC_MAX       = 80,
    localparam int PH_W          = (CYC_LEN > 1) ? $clog2(CYC_LEN) : 1,
    localparam int PC_W          = $clog2(PROC_MAX + 1)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              cal_pulse_ni,
    input  logic [DATA_W-1:0] sample_i,
    output logic              cal_busy_o,
    output logic              fine_busy_o,
    output logic [PH_W-1:0]   phase_o,
    output logic              proc_done_o,
    output logic [PC_W-1:0]   proc_count_o,
    output logic              cal_complete_o,
    output logic [DATA_W-1:0] sample_o
);

    logic fall;
    logic cyc_end;

    calseq_edge u_edge (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .strobe_ni (cal_pulse_ni),
        .fall_o    (fall)
    );

    calseq_timer #(
        .CYC_LEN    (CYC_LEN),
        .FINE_START (FINE_START),
        .FINE_LEN   (FINE_LEN)
    ) u_timer (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .fall_i  (fall),
        .busy_o  (cal_busy_o),
        .fine_o  (fine_busy_o),
        .end_o   (cyc_end),
        .phase_o (phase_o)
    );

    calseq_tally #(
        .UNITS_PER_PROC (UNITS_PER_PROC),
        .PROC_MAX       (PROC_MAX)
    ) u_tally (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .end_i      (cyc_end),
        .done_o     (proc_done_o),
        .complete_o (cal_complete_o),
        .count_o    (proc_count_o)
    );

    calseq_hold #(
        .DATA_W (DATA_W),
        .LO_W   (LO_W)
    ) u_hold (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .freeze_i (fine_busy_o),
        .sample_i (sample_i),
        .sample_o (sample_o)
    );

    a_r4_fine_inside_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fine_busy_o |-> cal_busy_o);

    a_r4_fine_bounds: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cal_busy_o && (phase_o == '0 || phase_o > PH_W'(FINE_START + FINE_LEN - 1))) |-> !fine_busy_o);

endmodule

// File: tb/tb_cal_cycle_seq.sv
module tb_cal_cycle_seq;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cal_n = 1'b1;
    logic [9:0] sample_in = '0;
    logic       busy, fine, done, complete;
    logic [2:0] phase;
    logic [6:0] pcount;
    logic [9:0] sample_out;

    int checks = 0;
    int errors = 0;
    int units = 0;
    int dones_seen = 0;

    always #2 clk = ~clk;

    cal_cycle_seq dut (
        .clk_i          (clk),
        .rst_ni         (rst_n),
        .cal_pulse_ni   (cal_n),
        .sample_i       (sample_in),
        .cal_busy_o     (busy),
        .fine_busy_o    (fine),
        .phase_o        (phase),
        .proc_done_o    (done),
        .proc_count_o   (pcount),
        .cal_complete_o (complete),
        .sample_o       (sample_out)
    );

    always @(negedge clk) if (rst_n && done) dones_seen++;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // R1
    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk("R1 busy", busy, 0);
        chk("R1 fine", fine, 0);
        chk("R1 phase", phase, 0);
        chk("R1 done", done, 0);
        chk("R1 count", pcount, 0);
        chk("R1 complete", complete, 0);
        chk("R1 sample", sample_out, 0);
    endtask

    // R2: strobe low at reset release must not start a cycle
    task automatic t_low_at_reset();
        rst_n = 1'b0;
        cal_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R2 no start when low at reset", busy, 0);
        cal_n = 1'b1;
        @(negedge clk);
    endtask

    // One detailed unit cycle: R2 R3 R4 R5 R7, optional retrigger (R6), optional held-low (R2)
    task automatic t_unit(input bit retrig, input bit hold_low, input int base);
        logic [9:0] d [0:8];
        int lo_exp;
        for (int i = 0; i < 9; i++) d[i] = 10'(base + i * 37 + i * i * 5);
        @(negedge clk);
        cal_n = 1'b0;
        sample_in = d[0];
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            if (k < 7) begin
                chk("R2/R3 busy in cycle", busy, 1);
                chk("R3 phase", phase, k);
                chk("R4 fine flag", fine, (k >= 1 && k <= 4) ? 1 : 0);
                chk("R7 no done mid cycle", done, 0);
            end else begin
                chk("R3 idle after 7 clocks", busy, 0);
                chk("R3 phase back to 0", phase, 0);
                chk("R7 done strobe", done, ((units + 1) % 7 == 0) ? 1 : 0);
            end
            chk("R5 high bits track", sample_out[9:5], d[k][9:5]);
            lo_exp = (k >= 2 && k <= 5) ? d[1][4:0] : d[k][4:0];
            chk("R5 low bits", sample_out[4:0], lo_exp);
            sample_in = d[k + 1];
            if (k == 0 && !hold_low) cal_n = 1'b1;
            if (retrig && k == 2) cal_n = 1'b0;
            if (retrig && k == 4) cal_n = 1'b1;
        end
        units++;
        @(negedge clk);
        chk("R6/R2 no queued or repeated start", busy, 0);
        chk("R7 done one clock", done, 0);
        cal_n = 1'b1;
    endtask

    task automatic fast_units(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            cal_n = 1'b0;
            @(negedge clk);
            cal_n = 1'b1;
            repeat (7) @(negedge clk);
            units++;
        end
    endtask

    // R7 R8: saturation
    task automatic t_saturate();
        fast_units(79 * 7 - units);
        repeat (2) @(negedge clk);
        chk("R8 count at 79", pcount, 79);
        chk("R8 not complete at 79", complete, 0);
        chk("R7 done count matches", dones_seen, 79);
        fast_units(7);
        repeat (2) @(negedge clk);
        chk("R8 count at 80", pcount, 80);
        chk("R8 complete at 80", complete, 1);
        fast_units(7);
        repeat (2) @(negedge clk);
        chk("R8 saturates at 80", pcount, 80);
        chk("R8 complete stays", complete, 1);
        chk("R7 done still fires", dones_seen, 81);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_low_at_reset();
        t_unit(1'b0, 1'b0, 3);
        t_unit(1'b1, 1'b0, 100);
        t_unit(1'b0, 1'b1, 517);
        for (int j = 0; j < 4; j++) t_unit(1'b0, 1'b0, 200 + j * 61);
        chk("R7 first process done once", dones_seen, 1);
        chk("R8 count after first process", pcount, 1);
        t_saturate();
        finish_run();
    end

endmodule